// File: doc/BRIEF.md
# Collision and Heartbeat Signal Generator

This block drives the single collision line that a 10/100 Ethernet PHY presents to its MAC. It watches two activity indications, one for the local transmitter and one for the receiver. In half duplex it raises the collision line whenever both are active at the same time. After every 10 Mb/s half-duplex transmission it also emits a short signal-quality test pulse, the heartbeat, on the same line, provided the heartbeat is enabled. Speed, duplex, heartbeat enable and the MAC-interface mode are static configuration inputs. The block samples them on every cycle of a free-running reference clock.

The heartbeat lasts about one microsecond. Its length is counted in reference-clock cycles and derived from a clock-frequency parameter. In reduced-pin mode the MAC works out collisions by itself, so the line is held low. In the 10 Mb serial mode the line is always treated as half duplex at 10 Mb/s.

Top module: `collhb_top`

## Requirements
- R1: While `rst_n` is low, and on the first edge after `rst_n` rises, `col` is 0.
- R2: `col` is registered and follows inputs sampled at each rising edge. In MII mode (`if_mode` 2'b00) with `full_duplex`=0, if `tx_active` and `rx_active` are both 1 at an edge, then `col` is 1 after that edge. This holds at both speeds.
- R3: In MII mode with `full_duplex`=1, `col` is 0 after every edge. This covers overlapping activity, the end of a transmission, and a heartbeat pulse already in progress.
- R4: In MII mode at 10 Mb/s (`speed_100`=0), half duplex, with `hb_enable`=1, a heartbeat pulse follows a transmission. The trigger is the first edge that samples `tx_active`=0 after an edge that sampled it as 1. `col` is then 1 for exactly HB cycles, starting after the next edge, unless R7 cuts the pulse short.
- R5: HB equals CLK_FREQ_HZ/1,000,000 rounded to the nearest integer, with a minimum of 1.
- R6: No heartbeat starts when `speed_100`=1 or `hb_enable`=0 at the edge where the end of transmission is seen.
- R7: If `tx_active` is sampled as 1 while a heartbeat is running, the pulse ends. If `rx_active` is 0 at that edge, `col` is 0 after it.
- R8: In reduced-pin mode (`if_mode` 2'b01), `col` is 0 after every edge.
- R9: In 10 Mb serial mode (`if_mode` 2'b10), `full_duplex` and `speed_100` are ignored. Overlapping activity sets `col`, and the heartbeat behaves as in R4 whenever `hb_enable`=1.
- R10: `if_mode` 2'b11 behaves exactly like MII mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | Local transmitter is sending |
| rx_active | input | 1 | Receiver sees activity on the line |
| speed_100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| full_duplex | input | 1 | 1 selects full duplex |
| hb_enable | input | 1 | Enables the end-of-transmit heartbeat |
| if_mode | input | 2 | 00 MII, 01 reduced-pin, 10 10 Mb serial, 11 MII |
| col | output | 1 | Collision / heartbeat indication to the MAC |

## Verification
The bench builds the block with CLK_FREQ_HZ set to 8,600,000. This gives a 9-cycle heartbeat, which is short enough that complete pulses, truncated pulses and back-to-back transmissions all fit in a few dozen cycles. The chosen value has a fractional part above one half, so a design that truncates the division instead of rounding gives 8 cycles, and the bench catches the difference. Configuration changes made while a pulse is running are also exercised, which checks that the duplex and mode gating acts on the output and not only on the start of the pulse.

// File: rtl/collhb_pkg.sv
package collhb_pkg;

  typedef enum logic [1:0] {
    IFM_MII     = 2'b00,
    IFM_RMII    = 2'b01,
    IFM_SERIAL  = 2'b10,
    IFM_MII_ALT = 2'b11
  } ifm_e;

  // Heartbeat length in reference cycles: nearest integer to f / 1 MHz, at least 1.
  function automatic int unsigned hb_cycles(input longint unsigned freq_hz);
    longint unsigned c;
    c = (freq_hz + 64'd500_000) / 64'd1_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/collhb_qualify.sv
module collhb_qualify
  import collhb_pkg::*;
(
  input  ifm_e mode,
  input  logic full_duplex,
  input  logic speed_100,
  input  logic hb_enable,
  output logic col_allowed,
  output logic hb_allowed
);
  logic is_serial;
  logic eff_half;
  logic eff_10m;

  always_comb begin
    is_serial   = (mode == IFM_SERIAL);
    eff_half    = is_serial || !full_duplex;
    eff_10m     = is_serial || !speed_100;
    col_allowed = (mode != IFM_RMII) && eff_half;
    hb_allowed  = col_allowed && eff_10m && hb_enable;
  end

endmodule

// File: rtl/collhb_txend.sv
module collhb_txend (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  output logic tx_fall
);
  logic tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_active;
  end

  assign tx_fall = tx_q && !tx_active;

endmodule

// File: rtl/collhb_pulse.sv
module collhb_pulse #(
  parameter int unsigned HB_CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(HB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HB_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (start)       cnt_q <= CNT_LOAD;
    else if (abort)       cnt_q <= '0;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R4
  AST_PULSE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !busy); // R7

endmodule

// File: rtl/collhb_top.sv
module collhb_top
  import collhb_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 25_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_active,
  input  logic       rx_active,
  input  logic       speed_100,
  input  logic       full_duplex,
  input  logic       hb_enable,
  input  logic [1:0] if_mode,
  output logic       col
);
  localparam int unsigned HB_CYCLES = hb_cycles(longint'(CLK_FREQ_HZ));

  ifm_e mode;
  logic col_allowed;
  logic hb_allowed;
  logic tx_fall;
  logic hb_start;
  logic hb_busy;
  logic overlap;
  logic col_d;

  assign mode = ifm_e'(if_mode);

  collhb_qualify u_qual (
    .mode        (mode),
    .full_duplex (full_duplex),
    .speed_100   (speed_100),
    .hb_enable   (hb_enable),
    .col_allowed (col_allowed),
    .hb_allowed  (hb_allowed)
  );

  collhb_txend u_txend (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .tx_fall   (tx_fall)
  );

  assign hb_start = tx_fall && hb_allowed;

  collhb_pulse #(.HB_CYCLES(HB_CYCLES)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .start (hb_start),
    .abort (tx_active),
    .busy  (hb_busy)
  );

  assign overlap = tx_active && rx_active;
  assign col_d   = col_allowed && (overlap || (hb_busy && !tx_active));

  always_ff @(posedge clk) begin
    if (!rst_n) col <= 1'b0;
    else        col <= col_d;
  end

  AST_FULL_DUPLEX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && mode != IFM_SERIAL) |=> !col); // R3
  AST_RMII_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IFM_RMII) |=> !col); // R8
  AST_OVERLAP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && rx_active && mode != IFM_RMII && (!full_duplex || mode == IFM_SERIAL)) |=> col); // R2
  AST_TX_ALONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !rx_active) |=> !col); // R7
  AST_NO_HB_AT_100: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_start) |-> (!speed_100 || mode == IFM_SERIAL) && hb_enable); // R6

endmodule

// File: tb/collhb_top_tb_top.sv
module collhb_top_tb_top;

  localparam int unsigned FREQ = 8_600_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_active = 1'b0;
  logic       rx_active = 1'b0;
  logic       speed_100 = 1'b0;
  logic       full_duplex = 1'b0;
  logic       hb_enable = 1'b0;
  logic [1:0] if_mode = 2'b00;
  logic       col;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  int hb_len;
  int hb_left = 0;
  bit prev_tx = 1'b0;
  bit exp_col = 1'b0;

  always #10 clk = ~clk;

  collhb_top #(.CLK_FREQ_HZ(FREQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_active(rx_active),
    .speed_100(speed_100), .full_duplex(full_duplex), .hb_enable(hb_enable),
    .if_mode(if_mode), .col(col)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // One clock: model the edge from the inputs present there, then compare.
  task automatic cyc(input string tag);
    bit allowed, hb_ok, ser;
    @(posedge clk);
    ser     = (if_mode == 2'b10);
    allowed = (if_mode != 2'b01) && (ser || !full_duplex);
    hb_ok   = allowed && hb_enable && (ser || !speed_100);
    if (!rst_n) begin
      exp_col = 0; hb_left = 0; prev_tx = 0;
    end else begin
      exp_col = allowed && ((tx_active && rx_active) || (hb_left > 0 && !tx_active));
      if (prev_tx && !tx_active && hb_ok) hb_left = hb_len;
      else if (tx_active)                 hb_left = 0;
      else if (hb_left > 0)               hb_left = hb_left - 1;
      prev_tx = tx_active;
    end
    #1;
    vectors = vectors + 1;
    if (col !== exp_col) begin
      errors = errors + 1;
      $display("FAIL %s: col actual=%b expected=%b at cycle %0d", tag, col, exp_col, cycles);
    end
  endtask

  task automatic run(input bit t, input bit r, input int n, input string tag);
    tx_active = t; rx_active = r;
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic cfg(input logic [1:0] m, input bit fd, input bit s100, input bit hb);
    if_mode = m; full_duplex = fd; speed_100 = s100; hb_enable = hb;
  endtask

  initial begin
    hb_len = $rtoi(real'(FREQ) / 1.0e6 + 0.5);   // R5: nearest count for 1 us
    if (hb_len < 1) hb_len = 1;

    cfg(2'b00, 0, 0, 1);
    run(1, 1, 3, "R1 reset");
    rst_n = 1'b1;
    run(0, 0, 2, "R1 after reset");

    // R2: overlap, 100 Mb/s half duplex, then 10 Mb/s without heartbeat
    cfg(2'b00, 0, 1, 1);
    run(1, 0, 2, "R2"); run(1, 1, 4, "R2"); run(0, 1, 2, "R2 R6"); run(0, 0, 12, "R6 100M");
    cfg(2'b00, 0, 0, 0);
    run(1, 1, 3, "R2 10M"); run(0, 0, 12, "R6 hb off");

    // R4/R5: full heartbeat after a 10 Mb/s half-duplex transmission
    cfg(2'b00, 0, 0, 1);
    run(1, 0, 5, "R4"); run(0, 0, 15, "R4 R5 pulse");
    run(1, 1, 2, "R4"); run(0, 1, 14, "R4 R5 rx still on");

    // R7: new transmission cuts the pulse short
    run(1, 0, 3, "R7"); run(0, 0, 3, "R7"); run(1, 0, 4, "R7 cut"); run(0, 0, 14, "R7 again");

    // R3: full duplex, and a switch to full duplex during a pulse
    cfg(2'b00, 1, 0, 1);
    run(1, 1, 3, "R3"); run(0, 0, 12, "R3 no hb");
    cfg(2'b00, 0, 0, 1);
    run(1, 0, 2, "R3"); run(0, 0, 3, "R3");
    cfg(2'b00, 1, 0, 1);
    run(0, 0, 4, "R3 mid pulse");
    cfg(2'b00, 0, 0, 1);
    run(0, 0, 8, "R3 back half");

    // R8: reduced-pin mode
    cfg(2'b01, 0, 0, 1);
    run(1, 1, 3, "R8"); run(1, 0, 2, "R8"); run(0, 0, 12, "R8 no hb");

    // R9: serial mode ignores duplex and speed
    cfg(2'b10, 1, 1, 1);
    run(1, 1, 3, "R9"); run(1, 0, 2, "R9"); run(0, 0, 14, "R9 hb");
    cfg(2'b10, 1, 1, 0);
    run(1, 0, 2, "R9"); run(0, 0, 10, "R9 hb off");

    // R10: code 11 acts as MII
    cfg(2'b11, 0, 0, 1);
    run(1, 1, 3, "R10"); run(0, 0, 14, "R10 hb");
    cfg(2'b11, 1, 0, 1);
    run(1, 1, 3, "R10 fd"); run(0, 0, 10, "R10 fd");

    // R1: reset in the middle of a pulse
    cfg(2'b00, 0, 0, 1);
    run(1, 0, 2, "R1"); run(0, 0, 2, "R1");
    rst_n = 1'b0;
    run(0, 0, 2, "R1 reset mid pulse");
    rst_n = 1'b1;
    run(0, 0, 10, "R1 after");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule